// File: doc/BRIEF.md
# Clock Source Switch Sequencer

This block moves the ATA bus clock of a two-channel disk controller between a PLL-derived source and the host bus clock without disturbing traffic. Each time a command is issued it decides which source the command needs: a write, or a host bus running at 66 MHz, calls for the PLL; anything else runs from the host bus clock. When the needed source differs from the one in use and the other channel is idle, it isolates both channels, changes the clock select, resets the channel logic, releases that reset and reconnects the channels, one timed step after another.

While that sequence runs, the command is held with a stall output and released as a one-cycle go pulse once the channels are back on the bus. Commands that need no change, or that arrive while the partner channel is busy, are passed on the very next cycle on the clock already in use. A busy flag marks the running sequence, and issue requests seen while it is high are dropped.

Top module: `clksrc_switch_seq`

## Requirements
- R1: The needed source is the PLL (select code 0x21) when the command is a write or the 66 MHz flag is set; otherwise it is the host bus clock (select code 0x23).
- R2: When the partner channel is not idle at issue, no sequence runs: busy stays low, the select is unchanged and the go pulse appears one cycle after issue.
- R3: When the needed source equals the current source (cur_pll_i, 1 = PLL), no sequence runs and the go pulse appears one cycle after issue.
- R4: A switch runs in this fixed order: both tristate enables high; then the new select is driven with channel reset high; then a one-cycle state-machine reset pulse on both channels with channel reset still high; then channel reset low; then both tristate enables low.
- R5: clk_sel_o only ever shows 0x21 or 0x23 and changes only on entry to the switch step.
- R6: Each of the five steps lasts exactly STEP_CYC cycles (default 4), so busy is high for 5*STEP_CYC cycles, starting the cycle after issue.
- R7: stall_o is high for the whole sequence, and the held command is passed on as a single cmd_go_o pulse in the cycle right after busy falls.
- R8: busy_o is high from the first isolate cycle through the last reconnect cycle; issue requests seen while it is high have no effect on any output.
- R9: After reset all controls are low and clk_sel_o shows 0x23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_issue_i | input | 1 | Command issue request, sampled each cycle |
| cmd_write_i | input | 1 | Issued command is a write |
| bus66_i | input | 1 | Host bus runs at 66 MHz |
| partner_idle_i | input | 1 | Other channel has no command in flight |
| cur_pll_i | input | 1 | Clock in use is the PLL (1) or host bus clock (0) |
| cmd_go_o | output | 1 | One-cycle pulse passing the command on |
| stall_o | output | 1 | Command held while the clock changes |
| busy_o | output | 1 | Switch sequence in progress |
| tri_en_o | output | NUM_CH | Per-channel bus tristate enable |
| clk_sel_o | output | SEL_W | Clock source select code |
| chan_rst_o | output | 1 | Channel logic reset |
| sm_rst_o | output | NUM_CH | Per-channel state-machine reset pulse |

## Verification
The hardest case to reach is a second issue arriving in the middle of a running switch with inputs that would, if accepted, demand the opposite source. The stimulus raises such an issue a few cycles into the isolate step, flipping the write flag and current-source input, and then checks that the timeline, the final select code and the single go pulse match those of the first command alone. Random commands mix all four policy inputs so that the partner-busy and same-source pass-through paths fall between full switches.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISO,
    ST_SWITCH,
    ST_SMRST,
    ST_RELEASE,
    ST_RECON,
    ST_GO
  } seq_state_t;

  // True for the five timed steps of a switch
  function automatic logic in_seq(seq_state_t s);
    return (s == ST_ISO) || (s == ST_SWITCH) || (s == ST_SMRST) ||
           (s == ST_RELEASE) || (s == ST_RECON);
  endfunction

  // True while the channels are held off the bus
  function automatic logic isolated(seq_state_t s);
    return (s == ST_ISO) || (s == ST_SWITCH) || (s == ST_SMRST) ||
           (s == ST_RELEASE);
  endfunction

endpackage

// File: rtl/clksrc_policy.sv
module clksrc_policy #(
  parameter int          SEL_W    = 8,
  parameter logic [7:0]  SEL_PLL  = 8'h21,
  parameter logic [7:0]  SEL_HOST = 8'h23
) (
  input  logic             write_i,
  input  logic             bus66_i,
  input  logic             partner_idle_i,
  input  logic             cur_pll_i,
  output logic             switch_o,
  output logic [SEL_W-1:0] target_sel_o
);

  logic need_pll;

  always_comb begin
    need_pll     = write_i | bus66_i;
    switch_o     = partner_idle_i && (need_pll != cur_pll_i);
    target_sel_o = need_pll ? SEL_W'(SEL_PLL) : SEL_W'(SEL_HOST);
  end

endmodule

// File: rtl/clksrc_step_timer.sv
module clksrc_step_timer #(
  parameter int STEP_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);

  localparam int CNT_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == CNT_LAST);

endmodule

// File: rtl/clksrc_seq_fsm.sv
module clksrc_seq_fsm
  import clksrc_pkg::*;
#(
  parameter int          NUM_CH   = 2,
  parameter int          SEL_W    = 8,
  parameter logic [7:0]  SEL_HOST = 8'h23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  logic              switch_i,
  input  logic [SEL_W-1:0]  target_sel_i,
  input  logic              last_i,
  output logic              timer_clr_o,
  output logic              timer_en_o,
  output logic              go_o,
  output logic              stall_o,
  output logic              busy_o,
  output logic [NUM_CH-1:0] tri_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              chan_rst_o,
  output logic [NUM_CH-1:0] sm_rst_o
);

  seq_state_t       state_q, state_n;
  logic             accept;
  logic [SEL_W-1:0] tgt_q;

  assign accept = ((state_q == ST_IDLE) || (state_q == ST_GO)) && issue_i;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE, ST_GO: begin
        if (accept) state_n = switch_i ? ST_ISO : ST_GO;
        else        state_n = ST_IDLE;
      end
      ST_ISO:     if (last_i) state_n = ST_SWITCH;
      ST_SWITCH:  if (last_i) state_n = ST_SMRST;
      ST_SMRST:   if (last_i) state_n = ST_RELEASE;
      ST_RELEASE: if (last_i) state_n = ST_RECON;
      ST_RECON:   if (last_i) state_n = ST_GO;
      default:    state_n = ST_IDLE;
    endcase
  end

  assign timer_en_o  = in_seq(state_q);
  assign timer_clr_o = !in_seq(state_q) || last_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      tgt_q      <= SEL_W'(SEL_HOST);
      go_o       <= 1'b0;
      stall_o    <= 1'b0;
      busy_o     <= 1'b0;
      tri_o      <= '0;
      sel_o      <= SEL_W'(SEL_HOST);
      chan_rst_o <= 1'b0;
      sm_rst_o   <= '0;
    end else begin
      state_q    <= state_n;
      if (accept && switch_i) tgt_q <= target_sel_i;
      go_o       <= (state_n == ST_GO);
      stall_o    <= in_seq(state_n);
      busy_o     <= in_seq(state_n);
      tri_o      <= {NUM_CH{isolated(state_n)}};
      chan_rst_o <= (state_n == ST_SWITCH) || (state_n == ST_SMRST);
      sm_rst_o   <= {NUM_CH{(state_n == ST_SMRST) && (state_q != ST_SMRST)}};
      if ((state_n == ST_SWITCH) && (state_q != ST_SWITCH)) sel_o <= tgt_q;
    end
  end

endmodule

// File: rtl/clksrc_switch_seq.sv
module clksrc_switch_seq #(
  parameter int          NUM_CH   = 2,
  parameter int          STEP_CYC = 4,
  parameter int          SEL_W    = 8,
  parameter logic [7:0]  SEL_PLL  = 8'h21,
  parameter logic [7:0]  SEL_HOST = 8'h23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_issue_i,
  input  logic              cmd_write_i,
  input  logic              bus66_i,
  input  logic              partner_idle_i,
  input  logic              cur_pll_i,
  output logic              cmd_go_o,
  output logic              stall_o,
  output logic              busy_o,
  output logic [NUM_CH-1:0] tri_en_o,
  output logic [SEL_W-1:0]  clk_sel_o,
  output logic              chan_rst_o,
  output logic [NUM_CH-1:0] sm_rst_o
);

  logic             do_switch;
  logic [SEL_W-1:0] target_sel;
  logic             step_last;
  logic             timer_clr;
  logic             timer_en;

  clksrc_policy #(
    .SEL_W    (SEL_W),
    .SEL_PLL  (SEL_PLL),
    .SEL_HOST (SEL_HOST)
  ) u_policy (
    .write_i        (cmd_write_i),
    .bus66_i        (bus66_i),
    .partner_idle_i (partner_idle_i),
    .cur_pll_i      (cur_pll_i),
    .switch_o       (do_switch),
    .target_sel_o   (target_sel)
  );

  clksrc_step_timer #(
    .STEP_CYC (STEP_CYC)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (timer_clr),
    .en_i   (timer_en),
    .last_o (step_last)
  );

  clksrc_seq_fsm #(
    .NUM_CH   (NUM_CH),
    .SEL_W    (SEL_W),
    .SEL_HOST (SEL_HOST)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .issue_i      (cmd_issue_i),
    .switch_i     (do_switch),
    .target_sel_i (target_sel),
    .last_i       (step_last),
    .timer_clr_o  (timer_clr),
    .timer_en_o   (timer_en),
    .go_o         (cmd_go_o),
    .stall_o      (stall_o),
    .busy_o       (busy_o),
    .tri_o        (tri_en_o),
    .sel_o        (clk_sel_o),
    .chan_rst_o   (chan_rst_o),
    .sm_rst_o     (sm_rst_o)
  );

endmodule

// File: rtl/clksrc_switch_seq_chk.sv
module clksrc_switch_seq_chk #(
  parameter int          NUM_CH   = 2,
  parameter int          SEL_W    = 8,
  parameter logic [7:0]  SEL_PLL  = 8'h21,
  parameter logic [7:0]  SEL_HOST = 8'h23
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_issue_i,
  input logic              cmd_write_i,
  input logic              bus66_i,
  input logic              partner_idle_i,
  input logic              cur_pll_i,
  input logic              cmd_go_o,
  input logic              stall_o,
  input logic              busy_o,
  input logic [NUM_CH-1:0] tri_en_o,
  input logic [SEL_W-1:0]  clk_sel_o,
  input logic              chan_rst_o,
  input logic [NUM_CH-1:0] sm_rst_o
);

  AST_SEL_CODE: assert property (@(posedge clk) disable iff (rst)
    (clk_sel_o == SEL_W'(SEL_PLL)) || (clk_sel_o == SEL_W'(SEL_HOST))); // R5

  AST_SEL_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    !$stable(clk_sel_o) |-> (busy_o && chan_rst_o)); // R5

  AST_CHRST_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    chan_rst_o |-> (tri_en_o == {NUM_CH{1'b1}})); // R4

  AST_SMRST_IN_CHRST: assert property (@(posedge clk) disable iff (rst)
    (sm_rst_o != '0) |-> (chan_rst_o && (sm_rst_o == {NUM_CH{1'b1}}))); // R4

  AST_SMRST_PULSE: assert property (@(posedge clk) disable iff (rst)
    (sm_rst_o != '0) |=> (sm_rst_o == '0)); // R4

  AST_GO_AFTER_SEQ: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> cmd_go_o); // R7

  AST_GO_NOT_STALLED: assert property (@(posedge clk) disable iff (rst)
    cmd_go_o |-> (!stall_o && !busy_o)); // R7

  AST_PARTNER_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cmd_issue_i && !busy_o && !partner_idle_i) |=> (!busy_o && cmd_go_o)); // R2

  AST_SAME_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (cmd_issue_i && !busy_o && ((cmd_write_i | bus66_i) == cur_pll_i))
    |=> (!busy_o && cmd_go_o)); // R3

  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy_o && cmd_issue_i) |=> !cmd_go_o || $fell(busy_o)); // R8

endmodule

bind clksrc_switch_seq clksrc_switch_seq_chk #(
  .NUM_CH   (NUM_CH),
  .SEL_W    (SEL_W),
  .SEL_PLL  (SEL_PLL),
  .SEL_HOST (SEL_HOST)
) u_chk (.*);

// File: tb/clksrc_switch_seq_bench.sv
module clksrc_switch_seq_bench;

  localparam int NUM_CH = 2;
  localparam int STEP   = 4;
  localparam int SEL_W  = 8;
  localparam logic [7:0] CODE_PLL  = 8'h21;
  localparam logic [7:0] CODE_HOST = 8'h23;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_issue = 1'b0;
  logic              cmd_write = 1'b0;
  logic              bus66 = 1'b0;
  logic              partner_idle = 1'b1;
  logic              cur_pll = 1'b0;
  logic              cmd_go;
  logic              stall;
  logic              busy;
  logic [NUM_CH-1:0] tri_en;
  logic [SEL_W-1:0]  clk_sel;
  logic              chan_rst;
  logic [NUM_CH-1:0] sm_rst;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] sel_model = CODE_HOST;

  always #2 clk = ~clk;

  clksrc_switch_seq #(
    .NUM_CH   (NUM_CH),
    .STEP_CYC (STEP),
    .SEL_W    (SEL_W),
    .SEL_PLL  (CODE_PLL),
    .SEL_HOST (CODE_HOST)
  ) u_clksrc_switch_seq (
    .clk            (clk),
    .rst            (rst),
    .cmd_issue_i    (cmd_issue),
    .cmd_write_i    (cmd_write),
    .bus66_i        (bus66),
    .partner_idle_i (partner_idle),
    .cur_pll_i      (cur_pll),
    .cmd_go_o       (cmd_go),
    .stall_o        (stall),
    .busy_o         (busy),
    .tri_en_o       (tri_en),
    .clk_sel_o      (clk_sel),
    .chan_rst_o     (chan_rst),
    .sm_rst_o       (sm_rst)
  );

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Expected selection policy (R1)
  function automatic logic [7:0] want_code(bit w, bit f66);
    return (w || f66) ? CODE_PLL : CODE_HOST;
  endfunction

  function automatic bit want_switch(bit w, bit f66, bit idle, bit cur);
    return idle && ((w || f66) != cur);
  endfunction

  // One command; k counts negedges after the issue edge.
  task automatic run_cmd(string tag, bit w, bit f66, bit idle, bit cur, bit intrude);
    bit         sw  = want_switch(w, f66, idle, cur);
    logic [7:0] tgt = want_code(w, f66);
    logic [7:0] old = sel_model;
    cmd_write = w; bus66 = f66; partner_idle = idle; cur_pll = cur;
    cmd_issue = 1'b1;
    @(negedge clk);
    cmd_issue = 1'b0;
    for (int k = 0; k <= 5*STEP + 1; k++) begin
      bit         e_busy = sw && (k < 5*STEP);
      bit         e_go   = sw ? (k == 5*STEP) : (k == 0);
      bit [1:0]   e_tri  = (sw && k < 4*STEP) ? 2'b11 : 2'b00;
      bit         e_crst = sw && (k >= STEP) && (k < 3*STEP);
      bit [1:0]   e_smr  = (sw && k == 2*STEP) ? 2'b11 : 2'b00;
      logic [7:0] e_sel  = (sw && k >= STEP) ? tgt : old;
      check($sformatf("%s/R8 busy k=%0d", tag, k), 16'(busy), 16'(e_busy));
      check($sformatf("%s/R7 stall k=%0d", tag, k), 16'(stall), 16'(e_busy));
      check($sformatf("%s/R7 go k=%0d", tag, k), 16'(cmd_go), 16'(e_go));
      check($sformatf("%s/R4 ctl k=%0d", tag, k),
            16'({tri_en, chan_rst, sm_rst}), 16'({e_tri, e_crst, e_smr}));
      check($sformatf("%s/R5 sel k=%0d", tag, k), 16'(clk_sel), 16'(e_sel));
      if (intrude && sw && k == 2) begin
        cmd_issue = 1'b1; cmd_write = ~w; bus66 = 1'b0; cur_pll = ~cur;
      end else begin
        cmd_issue = 1'b0;
      end
      @(negedge clk);
    end
    if (sw) sel_model = tgt;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check("R9 reset ctl", 16'({cmd_go, stall, busy, tri_en, chan_rst, sm_rst}), 16'd0);
    check("R9 reset sel", 16'(clk_sel), 16'(CODE_HOST));

    // Directed corner cases
    run_cmd("R1 write to PLL R6", 1, 0, 1, 0, 0);
    run_cmd("R3 write already PLL", 1, 0, 1, 1, 0);
    run_cmd("R1 read to host", 0, 0, 1, 1, 0);
    run_cmd("R2 partner busy", 1, 0, 0, 0, 0);
    run_cmd("R1 66MHz read to PLL", 0, 1, 1, 0, 0);
    run_cmd("R8 ignore mid-switch", 0, 0, 1, 1, 1);
    run_cmd("R3 read already host", 0, 0, 1, 0, 0);

    // Random mix
    for (int i = 0; i < 40; i++) begin
      bit w   = 1'($urandom);
      bit f   = 1'($urandom);
      bit idl = ($urandom % 4) != 0;
      bit cur = 1'($urandom);
      bit itr = 1'($urandom);
      run_cmd($sformatf("R1 rnd%0d", i), w, f, idl, cur, itr);
    end
    finish_up();
  end

endmodule